// File: doc/BRIEF.md
# Three-Compare PWM Timer Channel

This block is a single timer channel that produces one pulse-width-modulated output from a free-running up-counter and three compare values. The period value sets where the counter wraps. The rise value sets the count at which the output moves to its active level. The fall value sets the count at which the output goes back to its idle level. Because the two edges come from independent compare values, the pulse can be placed anywhere inside the period. A compare value above the period value is never reached, so that edge disappears. This gives exact 0% and 100% duty without any special mode.

Software selects the idle level, sets the three compare values and sets the run bit. Three sticky flags record which compares have matched. Each flag is cleared through its own strobe on the clear input. All outputs are registered and change on the clock edge that follows the cycle in which the counter equals a compare value.

Top module: `pwm_dual_edge_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the counter goes to 0, `pwmOut` takes the value of `idleLevel`, and all three bits of `matchFlags` go to 0.
- R2: While `run` is 1, the counter steps by one per clock from 0. In the cycle after it equals `perVal`, it reads 0 again, so one period lasts `perVal`+1 clocks. Period matches are seen on `matchFlags[0]`, which is set on the edge after the counter equals `perVal`.
- R3: When the counter equals `riseVal` and `riseVal` <= `perVal`, `pwmOut` takes the active level (the inverse of `idleLevel`) on the next edge.
- R4: When the counter equals `fallVal` and `fallVal` <= `perVal`, `pwmOut` returns to `idleLevel` on the next edge. The period wrap does not change `pwmOut` by itself.
- R5: If `fallVal` > `perVal`, no fall event occurs and `matchFlags[1]` is never set. Once the output is active it stays active (100% duty).
- R6: If `riseVal` > `perVal`, no rise event occurs and `matchFlags[2]` is never set. The output stays at `idleLevel` (0% duty).
- R7: With `idleLevel` = 1, the output starts high, a rise event drives it low and a fall event drives it high.
- R8: A match sets its flag: bit 0 for the period, bit 1 for fall, bit 2 for rise. The flag stays set until a clock edge where the matching bit of `flagClr` is 1, and then reads 0.
- R9: If a clear strobe and a new match on the same flag fall in the same cycle, the flag ends up set.
- R10: While `run` is 0, the counter, the output and the flags do not change, except for flags cleared through `flagClr`. Counting resumes from the held value.
- R11: When the fall and rise events occur in the same cycle, the fall event wins and the output goes to `idleLevel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Counter enable |
| perVal | input | 16 | Period compare value |
| fallVal | input | 16 | Compare value that returns the output to idle |
| riseVal | input | 16 | Compare value that drives the output active |
| idleLevel | input | 1 | Output level after reset and after a fall event |
| flagClr | input | 3 | Per-flag clear strobes (bit 0 period, 1 fall, 2 rise) |
| pwmOut | output | 1 | PWM output |
| matchFlags | output | 3 | Sticky match flags (bit 0 period, 1 fall, 2 rise) |

## Verification
The assertions assume that the counter never sits above the period value. If it did, it would run through the top of the 16-bit range before wrapping. They also assume that `idleLevel` does not change between an event and the edge that applies it. The bench keeps to this. It changes the compare values and the idle level only while reset is held, and it never lowers the period value below a count already reached. The vector table restarts the channel from reset for every entry, so each expected level follows from the number of edges counted since `run` was raised.

// File: rtl/pwmdt_pkg.sv
package pwmdt_pkg;

  // Index of each sticky flag in the flag vector
  localparam int FLAG_PER  = 0;
  localparam int FLAG_FALL = 1;
  localparam int FLAG_RISE = 2;
  localparam int NUM_FLAGS = 3;

  // Strobes from control to datapath; the packed order matches the flag index
  typedef struct packed {
    logic rise;
    logic fall;
    logic per;
  } hitStrobes_t;

endpackage

// File: rtl/pwmdt_ctrl.sv
module pwmdt_ctrl
  import pwmdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             run,
  input  logic [CNT_W-1:0] cntQ,
  input  logic [CNT_W-1:0] perVal,
  input  logic [CNT_W-1:0] fallVal,
  input  logic [CNT_W-1:0] riseVal,
  output hitStrobes_t      strb
);

  logic fallReachable;
  logic riseReachable;

  // An edge value above the period can never be reached, so its edge is dropped
  always_comb begin
    fallReachable = (fallVal <= perVal);
    riseReachable = (riseVal <= perVal);
  end

  always_comb begin
    strb.per  = run && (cntQ == perVal);
    strb.fall = run && fallReachable && (cntQ == fallVal);
    strb.rise = run && riseReachable && (cntQ == riseVal);
  end

endmodule

// File: rtl/pwmdt_dp.sv
module pwmdt_dp
  import pwmdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 idleLevel,
  input  hitStrobes_t          strb,
  input  logic [NUM_FLAGS-1:0] flagClr,
  output logic [CNT_W-1:0]     cntQ,
  output logic                 pwmQ,
  output logic [NUM_FLAGS-1:0] flagQ
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [NUM_FLAGS-1:0] hitVec;
  assign hitVec = strb;

  // Up-counter with wrap on the period match
  always_ff @(posedge clk) begin
    if (rst)           cntQ <= CNT_ZERO;
    else if (strb.per) cntQ <= CNT_ZERO;
    else if (run)      cntQ <= cntQ + CNT_ONE;
  end

  // Output level: the fall event takes priority over the rise event
  always_ff @(posedge clk) begin
    if (rst)            pwmQ <= idleLevel;
    else if (strb.fall) pwmQ <= idleLevel;
    else if (strb.rise) pwmQ <= ~idleLevel;
  end

  // Sticky flags: a new match wins over a clear in the same cycle
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flagQ[g] <= 1'b0;
      else if (hitVec[g])  flagQ[g] <= 1'b1;
      else if (flagClr[g]) flagQ[g] <= 1'b0;
    end
  end

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    strb.per |=> (cntQ == CNT_ZERO)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && !strb.per) |=> (cntQ == CNT_W'($past(cntQ) + CNT_ONE))); // R2
  AST_RISE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (strb.rise && !strb.fall) |=> (pwmQ != $past(idleLevel))); // R3
  AST_FALL_IDLE: assert property (@(posedge clk) disable iff (rst)
    strb.fall |=> (pwmQ == $past(idleLevel))); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flagQ[FLAG_PER] && !flagClr[FLAG_PER]) |=> flagQ[FLAG_PER]); // R8
  AST_MATCH_WINS: assert property (@(posedge clk) disable iff (rst)
    strb.per |=> flagQ[FLAG_PER]); // R9
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(cntQ) && $stable(pwmQ))); // R10

endmodule

// File: rtl/pwm_dual_edge_timer.sv
module pwm_dual_edge_timer
  import pwmdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic [CNT_W-1:0]     perVal,
  input  logic [CNT_W-1:0]     fallVal,
  input  logic [CNT_W-1:0]     riseVal,
  input  logic                 idleLevel,
  input  logic [NUM_FLAGS-1:0] flagClr,
  output logic                 pwmOut,
  output logic [NUM_FLAGS-1:0] matchFlags
);

  hitStrobes_t      strb;
  logic [CNT_W-1:0] cntQ;

  pwmdt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .run     (run),
    .cntQ    (cntQ),
    .perVal  (perVal),
    .fallVal (fallVal),
    .riseVal (riseVal),
    .strb    (strb)
  );

  pwmdt_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .idleLevel (idleLevel),
    .strb      (strb),
    .flagClr   (flagClr),
    .cntQ      (cntQ),
    .pwmQ      (pwmOut),
    .flagQ     (matchFlags)
  );

endmodule

// File: tb/pwm_dual_edge_timer_tb.sv
`timescale 1ns/1ps
module pwm_dual_edge_timer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [15:0] perVal = '0;
  logic [15:0] fallVal = '0;
  logic [15:0] riseVal = '0;
  logic        idleLevel = 1'b0;
  logic [2:0]  flagClr = '0;
  logic        pwmOut;
  logic [2:0]  matchFlags;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pwm_dual_edge_timer u_dut (
    .clk(clk), .rst(rst), .run(run), .perVal(perVal), .fallVal(fallVal),
    .riseVal(riseVal), .idleLevel(idleLevel), .flagClr(flagClr),
    .pwmOut(pwmOut), .matchFlags(matchFlags)
  );

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] fall;
    logic [15:0] rise;
    logic        idle;
    logic [7:0]  edges;
    logic        expOut;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{16'd9, 16'd6,  16'd2,  1'b0, 8'd2,  1'b0, 4'd3},  // R3 before rise
    '{16'd9, 16'd6,  16'd2,  1'b0, 8'd3,  1'b1, 4'd3},  // R3 after rise
    '{16'd9, 16'd6,  16'd2,  1'b0, 8'd6,  1'b1, 4'd4},  // R4 before fall
    '{16'd9, 16'd6,  16'd2,  1'b0, 8'd7,  1'b0, 4'd4},  // R4 after fall
    '{16'd9, 16'd6,  16'd2,  1'b0, 8'd12, 1'b0, 4'd2},  // R2 second period, pre-rise
    '{16'd9, 16'd6,  16'd2,  1'b0, 8'd13, 1'b1, 4'd2},  // R2 second period rise
    '{16'd9, 16'd20, 16'd3,  1'b0, 8'd25, 1'b1, 4'd5},  // R5 stays active
    '{16'd9, 16'd20, 16'd3,  1'b0, 8'd3,  1'b0, 4'd5},  // R5 not yet risen
    '{16'd9, 16'd2,  16'd20, 1'b0, 8'd25, 1'b0, 4'd6},  // R6 never rises
    '{16'd9, 16'd6,  16'd2,  1'b1, 8'd1,  1'b1, 4'd7},  // R7 starts high
    '{16'd9, 16'd6,  16'd2,  1'b1, 8'd3,  1'b0, 4'd7},  // R7 active low
    '{16'd9, 16'd6,  16'd2,  1'b1, 8'd7,  1'b1, 4'd7},  // R7 back high
    '{16'd9, 16'd4,  16'd4,  1'b0, 8'd5,  1'b0, 4'd11}, // R11 fall wins
    '{16'd9, 16'd1,  16'd5,  1'b0, 8'd11, 1'b1, 4'd4},  // R4 wrap leaves level
    '{16'd9, 16'd1,  16'd5,  1'b0, 8'd12, 1'b0, 4'd4},  // R4 fall in next period
    '{16'd0, 16'd1,  16'd0,  1'b0, 8'd1,  1'b1, 4'd5},  // R5 period of one
    '{16'd0, 16'd1,  16'd0,  1'b0, 8'd7,  1'b1, 4'd5},  // R5 period of one held
    '{16'd9, 16'd4,  16'd4,  1'b1, 8'd5,  1'b1, 4'd11}  // R11 fall wins, idle high
  };

  task automatic chk(input int act, input int exp, input int req, input string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reset with a new configuration, raise run, then wait for a number of edges
  task automatic startRun(input logic [15:0] p, input logic [15:0] f,
                          input logic [15:0] r, input logic idl, input int edges);
    @(negedge clk);
    rst = 1'b1; run = 1'b0; flagClr = '0;
    perVal = p; fallVal = f; riseVal = r; idleLevel = idl;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; run = 1'b1;
    repeat (edges) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    // R1: reset state for both idle levels
    startRun(16'd9, 16'd6, 16'd2, 1'b0, 0);
    chk(pwmOut, 0, 1, "reset output idle 0");
    chk(matchFlags, 0, 1, "reset flags");
    startRun(16'd9, 16'd6, 16'd2, 1'b1, 0);
    chk(pwmOut, 1, 1, "reset output idle 1");

    // Vector table
    for (int i = 0; i < NV; i++) begin
      startRun(VECS[i].per, VECS[i].fall, VECS[i].rise, VECS[i].idle, int'(VECS[i].edges));
      chk(pwmOut, VECS[i].expOut, VECS[i].req, $sformatf("vector %0d output", i));
    end

    // R8: rise flag set by a rise match only
    startRun(16'd9, 16'd6, 16'd2, 1'b0, 3);
    chk(matchFlags, 3'b100, 8, "rise flag only");

    // R2/R8/R9: period flag timing, clear, re-set and clear collision
    startRun(16'd4, 16'd20, 16'd20, 1'b0, 4);
    chk(matchFlags[0], 0, 2, "period flag before match");
    step(1);
    chk(matchFlags[0], 1, 2, "period flag after match");
    flagClr = 3'b001;
    step(1);
    flagClr = 3'b000;
    chk(matchFlags[0], 0, 8, "period flag cleared");
    step(3);
    chk(matchFlags[0], 0, 8, "period flag stays clear");
    step(1);
    chk(matchFlags[0], 1, 2, "period flag after second period");
    step(4);
    chk(matchFlags[0], 1, 8, "period flag sticky");
    flagClr = 3'b001;
    step(1);
    flagClr = 3'b000;
    chk(matchFlags[0], 1, 9, "match wins over clear");
    chk(matchFlags[1], 0, 5, "fall flag suppressed");
    chk(matchFlags[2], 0, 6, "rise flag suppressed");

    // R10: stop holds counter and output, resume continues from held count
    startRun(16'd9, 16'd6, 16'd2, 1'b0, 4);
    run = 1'b0;
    step(10);
    chk(pwmOut, 1, 10, "output held while stopped");
    chk(matchFlags[1], 0, 10, "no fall while stopped");
    run = 1'b1;
    step(2);
    chk(pwmOut, 1, 10, "resume before fall");
    step(1);
    chk(pwmOut, 0, 10, "resume fall at held count plus two");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule